// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block shifts or rotates a data word by a variable amount in a single cycle and reports the carry flag that the operation produces, ready for a downstream ALU. A caller presents an operand, a three-bit operation code, an eight-bit amount and the current carry flag together with a valid strobe. The block returns the shifted word, the new carry and a valid strobe.

Five operations are supported. Logical left shift, logical right shift, arithmetic right shift and rotate right take a variable amount. The fifth operation rotates right by exactly one position through the incoming carry. An amount of zero, an amount equal to the word width, and an amount beyond the word width each have their own defined result and carry, so the caller never has to special-case them. By default the result is registered. Setting a parameter turns the block into pure combinational logic.

Top module: `bsh_barrel`

## Requirements
- R1: Operation code 0 is logical left shift. For an amount n from 1 to 31 the result is operand shifted left by n, and the carry is operand bit (32−n). For n = 32 the result is 0 and the carry is operand bit 0.
- R2: Operation code 1 is logical right shift. For n from 1 to 32 the result is operand shifted right by n with zeros filled in, and the carry is operand bit (n−1). This makes n = 32 give result 0 and carry equal to operand bit 31.
- R3: Operation code 2 is arithmetic right shift. For n from 1 to 31 vacated bits take operand bit 31, and the carry is operand bit (n−1). For n of 32 or more every result bit and the carry equal operand bit 31.
- R4: Operation code 3 is rotate right. For a nonzero amount the word rotates by the amount modulo 32, and the carry equals bit 31 of the result. A nonzero multiple of 32 therefore returns the operand unchanged with carry equal to its bit 31.
- R5: Operation code 4 returns {carry_in, operand[31:1]} with carry equal to operand bit 0, whatever the amount.
- R6: For operation codes 0 to 3 with amount 0, the result equals the operand and the carry equals the incoming carry.
- R7: For operation codes 0 and 1 with an amount above 32, the result is 0 and the carry is 0.
- R8: Operation codes 5, 6 and 7 return the operand unchanged with the incoming carry.
- R9: With the output register enabled, out_valid is high exactly in the cycle after a cycle with in_valid high. After reset, out_valid, out_result and out_carry are 0.
- R10: In a cycle without in_valid, the registered out_result and out_carry keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word and controls are valid this cycle |
| in_operand | input | 32 | Word to shift |
| in_kind | input | 3 | Operation code (0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 rotate-through-carry) |
| in_amount | input | 8 | Shift amount, 0 to 255 |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result is valid |
| out_result | output | 32 | Shifted word |
| out_carry | output | 1 | Carry produced by the shift |

## Verification
A wrongly classified amount, such as treating 32 as out of range or missing the zero case, shows up at the ports as a wrong result or carry in the cycle right after the input is accepted. There is no hidden state beyond the output register. Every amount from 0 to 40 is swept for each operation, along with the extremes 63, 64, 128 and 255. Each sweep uses operands that have bit 31 set and clear, so a carry bit picked from the wrong position or a wrong sign fill changes the output at once. Hold behaviour is checked by changing the inputs while valid is low. Wrong latency is checked by sampling out_valid in the cycles on both sides of the accepted input.

// File: rtl/bsh_pkg.sv
`timescale 1ns/1ps
package bsh_pkg;

  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;

  // classification of the amount relative to the data width
  typedef struct packed {
    logic zero;   // amount is exactly zero
    logic over;   // amount is strictly above the width
  } amt_class_t;

endpackage

// File: rtl/bsh_amt_class.sv
`timescale 1ns/1ps
module bsh_amt_class
  import bsh_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  localparam int CW   = $clog2(W + 1),
  localparam int LW   = $clog2(W)
) (
  input  logic [AMT_W-1:0] amount,
  output amt_class_t       cls,
  output logic [CW-1:0]    amt_clamp,
  output logic [LW-1:0]    amt_rot
);

  // saturate the amount at W: shifts by W or more behave alike once clamped
  function automatic logic [CW-1:0] clamp_amt(input logic [AMT_W-1:0] a);
    if (a >= AMT_W'(W)) return CW'(W);
    return CW'(a);
  endfunction

  function automatic logic [LW-1:0] mod_amt(input logic [AMT_W-1:0] a);
    return LW'(a % AMT_W'(W));
  endfunction

  always_comb begin
    cls.zero  = (amount == '0);
    cls.over  = (amount > AMT_W'(W));
    amt_clamp = clamp_amt(amount);
    amt_rot   = mod_amt(amount);
  end

endmodule

// File: rtl/bsh_datapath.sv
`timescale 1ns/1ps
module bsh_datapath
  import bsh_pkg::*;
#(
  parameter int W   = 32,
  localparam int CW = $clog2(W + 1),
  localparam int LW = $clog2(W)
) (
  input  logic [W-1:0]  operand,
  input  logic [2:0]    kind,
  input  logic          carry_in,
  input  amt_class_t    cls,
  input  logic [CW-1:0] amt_clamp,
  input  logic [LW-1:0] amt_rot,
  output logic [W-1:0]  result,
  output logic          carry_out
);

  // {carry, result} for a left shift; the bit shifted out last lands on top
  function automatic logic [W:0] f_lsl(input logic [W-1:0] op, input logic [CW-1:0] n);
    logic [W:0] e;
    e = {1'b0, op} << n;
    return e;
  endfunction

  // {result, carry} for a logical right shift; the last bit out lands at the bottom
  function automatic logic [W:0] f_lsr(input logic [W-1:0] op, input logic [CW-1:0] n);
    logic [W:0] e;
    e = {op, 1'b0} >> n;
    return e;
  endfunction

  // {result, carry} for an arithmetic right shift; n saturates at W
  function automatic logic [W:0] f_asr(input logic [W-1:0] op, input logic [CW-1:0] n);
    logic signed [W:0] e;
    e = $signed({op, 1'b0}) >>> n;
    return e;
  endfunction

  function automatic logic [W-1:0] f_ror(input logic [W-1:0] op, input logic [LW-1:0] r);
    return (op >> r) | (op << (W - int'(r)));
  endfunction

  logic [W:0]   lsl_v, lsr_v, asr_v;
  logic [W-1:0] ror_v;

  assign lsl_v = f_lsl(operand, amt_clamp);
  assign lsr_v = f_lsr(operand, amt_clamp);
  assign asr_v = f_asr(operand, amt_clamp);
  assign ror_v = f_ror(operand, amt_rot);

  always_comb begin
    result    = operand;
    carry_out = carry_in;
    case (kind)
      SK_LSL: begin
        if (cls.over) begin
          result    = '0;
          carry_out = 1'b0;
        end else if (!cls.zero) begin
          {carry_out, result} = lsl_v;
        end
      end
      SK_LSR: begin
        if (cls.over) begin
          result    = '0;
          carry_out = 1'b0;
        end else if (!cls.zero) begin
          {result, carry_out} = lsr_v;
        end
      end
      SK_ASR: begin
        if (!cls.zero) {result, carry_out} = asr_v;
      end
      SK_ROR: begin
        if (!cls.zero) begin
          result    = ror_v;
          carry_out = ror_v[W-1];
        end
      end
      SK_RRX: begin
        result    = {carry_in, operand[W-1:1]};
        carry_out = operand[0];
      end
      default: begin
        result    = operand;
        carry_out = carry_in;
      end
    endcase
  end

endmodule

// File: rtl/bsh_out_stage.sv
`timescale 1ns/1ps
module bsh_out_stage #(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         d_valid,
  input  logic [W-1:0] d_result,
  input  logic         d_carry,
  output logic         q_valid,
  output logic [W-1:0] q_result,
  output logic         q_carry
);

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q_valid  <= 1'b0;
          q_result <= '0;
          q_carry  <= 1'b0;
        end else begin
          q_valid <= d_valid;
          if (d_valid) begin
            q_result <= d_result;
            q_carry  <= d_carry;
          end
        end
      end
    end else begin : g_comb
      assign q_valid  = d_valid;
      assign q_result = d_result;
      assign q_carry  = d_carry;
    end
  endgenerate

endmodule

// File: rtl/bsh_barrel.sv
`timescale 1ns/1ps
module bsh_barrel
  import bsh_pkg::*;
#(
  parameter int W       = 32,
  parameter int AMT_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W-1:0]     in_operand,
  input  logic [2:0]       in_kind,
  input  logic [AMT_W-1:0] in_amount,
  input  logic             in_carry,
  output logic             out_valid,
  output logic [W-1:0]     out_result,
  output logic             out_carry
);

  localparam int CW = $clog2(W + 1);
  localparam int LW = $clog2(W);

  amt_class_t    amt_cls;
  logic [CW-1:0] amt_clamp;
  logic [LW-1:0] amt_rot;
  logic [W-1:0]  core_result;
  logic          core_carry;

  bsh_amt_class #(.W(W), .AMT_W(AMT_W)) i_class (
    .amount    (in_amount),
    .cls       (amt_cls),
    .amt_clamp (amt_clamp),
    .amt_rot   (amt_rot)
  );

  bsh_datapath #(.W(W)) i_dp (
    .operand   (in_operand),
    .kind      (in_kind),
    .carry_in  (in_carry),
    .cls       (amt_cls),
    .amt_clamp (amt_clamp),
    .amt_rot   (amt_rot),
    .result    (core_result),
    .carry_out (core_carry)
  );

  bsh_out_stage #(.W(W), .OUT_REG(OUT_REG)) i_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_valid  (in_valid),
    .d_result (core_result),
    .d_carry  (core_carry),
    .q_valid  (out_valid),
    .q_result (out_result),
    .q_carry  (out_carry)
  );

endmodule

// File: rtl/bsh_barrel_chk.sv
`timescale 1ns/1ps
module bsh_barrel_chk #(
  parameter int W       = 32,
  parameter int AMT_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [W-1:0]     in_operand,
  input logic [2:0]       in_kind,
  input logic [AMT_W-1:0] in_amount,
  input logic             in_carry,
  input logic             out_valid,
  input logic [W-1:0]     out_result,
  input logic             out_carry
);

  generate
    if (OUT_REG) begin : g_chk
      p_valid_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_carry)));
      p_zero_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind < 3'd4 && in_amount == '0) |=>
          (out_result == $past(in_operand) && out_carry == $past(in_carry)));
      p_logic_over_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind < 3'd2 && in_amount > AMT_W'(W)) |=>
          (out_result == '0 && !out_carry));
      p_asr_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 3'd2 && in_amount >= AMT_W'(W)) |=>
          (out_result == {W{$past(in_operand[W-1])}} && out_carry == $past(in_operand[W-1])));
      p_ror_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 3'd3 && in_amount != '0) |=>
          (out_carry == out_result[W-1]));
      p_rrx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 3'd4) |=>
          (out_carry == $past(in_operand[0]) && out_result[W-1] == $past(in_carry)));
      p_undef_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind > 3'd4) |=>
          (out_result == $past(in_operand) && out_carry == $past(in_carry)));
    end
  endgenerate

endmodule

bind bsh_barrel bsh_barrel_chk #(.W(W), .AMT_W(AMT_W), .OUT_REG(OUT_REG)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_operand (in_operand),
  .in_kind    (in_kind),
  .in_amount  (in_amount),
  .in_carry   (in_carry),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_carry  (out_carry)
);

// File: tb/test_bsh_barrel.sv
`timescale 1ns/1ps
module test_bsh_barrel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_operand = '0;
  logic [2:0]  in_kind = '0;
  logic [7:0]  in_amount = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_carry;

  int checks = 0;
  int bad = 0;

  always #2 clk = ~clk;

  bsh_barrel i_bsh_barrel (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
    .in_kind(in_kind), .in_amount(in_amount), .in_carry(in_carry),
    .out_valid(out_valid), .out_result(out_result), .out_carry(out_carry)
  );

  // bit-by-bit model written from the requirement list
  task automatic model(input logic [31:0] op, input logic [2:0] k, input int a,
                       input logic ci, output logic [31:0] r, output logic c);
    r = op;
    c = ci;
    case (k)
      3'd0: if (a > 32) begin r = 0; c = 0; end
            else if (a > 0) begin
              for (int i = 0; i < 32; i++) r[i] = (i >= a) ? op[i-a] : 1'b0;
              c = op[32-a];
            end
      3'd1: if (a > 32) begin r = 0; c = 0; end
            else if (a > 0) begin
              for (int i = 0; i < 32; i++) r[i] = (i + a < 32) ? op[i+a] : 1'b0;
              c = op[a-1];
            end
      3'd2: if (a > 0) begin
              for (int i = 0; i < 32; i++) r[i] = (i + a < 32) ? op[i+a] : op[31];
              c = (a >= 32) ? op[31] : op[a-1];
            end
      3'd3: if (a > 0) begin
              for (int i = 0; i < 32; i++) r[i] = op[(i + (a % 32)) % 32];
              c = r[31];
            end
      3'd4: begin
              for (int i = 0; i < 31; i++) r[i] = op[i+1];
              r[31] = ci;
              c = op[0];
            end
      default: ;
    endcase
  endtask

  function automatic string req_of(input logic [2:0] k, input int a);
    if (k > 3'd4) return "R8";
    if (k == 3'd4) return "R5";
    if (a == 0) return "R6";
    if (k < 3'd2 && a > 32) return "R7";
    case (k)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // present one accepted input, then sample after the output register has taken it
  task automatic apply_and_check(input logic [31:0] op, input logic [2:0] k,
                                 input int a, input logic ci);
    logic [31:0] er;
    logic        ec;
    string       rq;
    @(negedge clk);
    in_operand = op; in_kind = k; in_amount = 8'(a); in_carry = ci; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model(op, k, a, ci, er, ec);
    rq = req_of(k, a);
    check(rq, out_result, er);
    check(rq, {31'd0, out_carry}, {31'd0, ec});
  endtask

  task automatic t_reset;
    check("R9", {31'd0, out_valid}, 32'd0);
    check("R9", out_result, 32'd0);
    check("R9", {31'd0, out_carry}, 32'd0);
  endtask

  task automatic t_sweep(input logic [2:0] k, input logic [31:0] op, input logic ci);
    for (int a = 0; a <= 40; a++) apply_and_check(op, k, a, ci);
    apply_and_check(op, k, 63, ci);
    apply_and_check(op, k, 64, ci);
    apply_and_check(op, k, 128, ci);
    apply_and_check(op, k, 255, ci);
  endtask

  task automatic t_corners;
    // R1 amount 32 moves bit 0 into the carry
    apply_and_check(32'h0000_0001, 3'd0, 32, 1'b0);
    check("R1", {31'd0, out_carry}, 32'd1);
    // R2 amount 32 moves bit 31 into the carry
    apply_and_check(32'h8000_0000, 3'd1, 32, 1'b0);
    check("R2", {31'd0, out_carry}, 32'd1);
    // R4 rotate by 64 leaves operand unchanged
    apply_and_check(32'h8123_4567, 3'd3, 64, 1'b0);
    check("R4", out_result, 32'h8123_4567);
    // R5 rotate-through-carry ignores amount
    apply_and_check(32'h0000_0003, 3'd4, 200, 1'b1);
    check("R5", out_result, 32'h8000_0001);
    for (int k = 5; k < 8; k++) apply_and_check(32'hCAFE_F00D, 3'(k), 7, 1'b1);
  endtask

  task automatic t_latency_hold;
    logic [31:0] prev_r;
    logic        prev_c;
    @(negedge clk);
    check("R9", {31'd0, out_valid}, 32'd0);
    apply_and_check(32'h1234_5678, 3'd0, 4, 1'b0);
    check("R9", {31'd0, out_valid}, 32'd1);
    prev_r = out_result;
    prev_c = out_carry;
    in_operand = 32'hFFFF_FFFF; in_kind = 3'd4; in_amount = 8'd1; in_carry = ~prev_c;
    @(negedge clk);
    check("R9", {31'd0, out_valid}, 32'd0);
    check("R10", out_result, prev_r);
    check("R10", {31'd0, out_carry}, {31'd0, prev_c});
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_latency_hold();
    for (int k = 0; k < 5; k++) begin
      t_sweep(3'(k), 32'h8765_4321, 1'b0);
      t_sweep(3'(k), 32'h5A5A_0F0F, 1'b1);
      t_sweep(3'(k), 32'hFFFF_FFFE, 1'b1);
    end
    t_corners();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule